// File: doc/BRIEF.md
# Nested Center-Aligned Gate Pattern Generator

This block drives one bridge leg where each side (high and low) is built from two switch groups in parallel. One group switches fast with short edges; the other is slower but has lower on-resistance. A triangular up/down carrier is compared against a duty threshold. Each side gets a wide fast-group gate and a narrower slow-group gate that sits inside it, set in by a programmable inset on both edges. A programmable dead gap keeps the two sides from ever conducting together.

Every gate output is active high, and 0 is the safe level. The downstream link inverts, so all-zero gates leave the leg resting on its low side, and reset and disable both produce all-zero gates. Configuration is written into a staging copy. That copy becomes active only at carrier turning points: the peak, or both peak and bottom when dual reload is selected. A single-cycle converter trigger fires at every peak, which is the middle of the low-side interval.

The gates are referenced to the carrier level `c`, which runs 0,1,…,P,P−1,…,1 and then repeats. The effective duty is `D = min(duty, P)`.

Top module: `ncp_top`

## Requirements
- R1: The carrier counts up from 0 to the active period P and then back down to 0, so one PWM period lasts 2·P clocks. `adc_trig` is high for exactly one clock per period, on the peak level. At that moment the slow low gate is on whenever it is enabled for the period.
- R2: `hi_fast` is on while c < D. This gives 2·D−1 on-clocks per period for D ≥ 1. A duty of 0 keeps it off for the whole period, and a duty above P is treated as P.
- R3: `lo_fast` is on while c ≥ D+T, where T is the dead time. This gives 2·(P−D−T)+1 on-clocks when D+T ≤ P and none otherwise. No high gate is ever on in the same clock as a low gate.
- R4: `hi_slow` is on while c+S < D and `lo_slow` is on while c ≥ D+T+S, where S is the inset. Each slow gate is only ever on while its fast gate is on.
- R5: `hi_slow` stays off for the whole period when D is below the minimum on-width M. `lo_slow` stays off when the low level width P+1−D−T is below M.
- R6: While `rst_n` is low (synchronous), all four gates, `adc_trig` and `reload_pulse` are 0, and the carrier restarts at level 0 counting up. The reset period is 16 and the reset duty is 0.
- R7: When `en` is low, all four gates are 0 from the next clock. After `en` rises again, the gates stay 0 until the carrier has passed the bottom (level 0). They resume at level 1.
- R8: A write (`wr_en`) updates only the staging copy. With `reload_both`=0 the staging copy is taken over at each peak. With `reload_both`=1 it is also taken over at each bottom. `reload_pulse` is high for one clock at every take-over. A period below 2 is raised to 2 at take-over.
- R9: All outputs are registered. The output for carrier level k appears one clock after that level, so after reset is released the first `adc_trig` is seen 17 clocks later with the reset period of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Gate enable; low forces all gates off |
| reload_both | input | 1 | 1: take over configuration at bottom as well as peak |
| wr_en | input | 1 | Write all five staging values |
| wr_period | input | 16 | Carrier peak level P |
| wr_duty | input | 16 | Duty threshold |
| wr_dead | input | 16 | Dead gap T in carrier levels |
| wr_inset | input | 16 | Slow-gate inset S per edge |
| wr_minon | input | 16 | Slow-gate minimum width M |
| hi_fast | output | 1 | High-side fast gate |
| hi_slow | output | 1 | High-side slow gate |
| lo_fast | output | 1 | Low-side fast gate |
| lo_slow | output | 1 | Low-side slow gate |
| adc_trig | output | 1 | One-clock converter trigger at the carrier peak |
| reload_pulse | output | 1 | One-clock strobe at each configuration take-over |

## Verification
The gate on-counts are measured over whole peak-to-peak windows for several settings: a mid duty, a short period, a zero duty, and a duty above the period. Together these separate the comparator edges, the clamp and the dead gap. Two settings put one slow gate just under its minimum width, which separates the suppression check on each side from the inset arithmetic. A write made just after a peak, once in peak-only mode and once in dual mode, shows whether the new duty reaches the current pulse: it must not in peak-only mode, and must from the bottom on in dual mode. An enable dropout and re-arm shows that the gates stay quiet until the bottom.

// File: rtl/ncp_pkg.sv
package ncp_pkg;
    localparam int unsigned CW = 16;
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t MIN_PER = cnt_t'(2);

    typedef struct packed {
        cnt_t period;
        cnt_t duty;
        cnt_t dead;
        cnt_t inset;
        cnt_t minon;
    } cfg_t;

    typedef struct packed {
        logic hi_fast;
        logic hi_slow;
        logic lo_fast;
        logic lo_slow;
    } gate_t;
endpackage

// File: rtl/ncp_carrier.sv
module ncp_carrier
    import ncp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t period,
    output cnt_t count,
    output logic at_top,
    output logic at_bot
);
    typedef struct packed {
        cnt_t cnt;
        logic up;
    } car_t;

    car_t car_d, car_q;

    always_comb begin
        car_d  = car_q;
        at_top = car_q.up && (car_q.cnt >= period);
        at_bot = (car_q.cnt == '0);
        if (car_q.up) begin
            if (at_top) begin
                car_d.up  = 1'b0;
                car_d.cnt = car_q.cnt - cnt_t'(1);
            end else begin
                car_d.cnt = car_q.cnt + cnt_t'(1);
            end
        end else if (at_bot) begin
            car_d.up  = 1'b1;
            car_d.cnt = cnt_t'(1);
        end else begin
            car_d.cnt = car_q.cnt - cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q <= '{cnt: '0, up: 1'b1};
        end else begin
            car_q <= car_d;
        end
    end

    assign count = car_q.cnt;
endmodule

// File: rtl/ncp_shadow.sv
module ncp_shadow
    import ncp_pkg::*;
#(
    parameter cfg_t RST_CFG = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cfg_t wr_cfg,
    input  logic load,
    output cfg_t active
);
    typedef struct packed {
        cfg_t pend;
        cfg_t act;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (wr_en) begin
            shd_d.pend = wr_cfg;
        end
        if (load) begin
            shd_d.act = shd_q.pend;
            if (shd_q.pend.period < MIN_PER) begin
                shd_d.act.period = MIN_PER;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '{pend: RST_CFG, act: RST_CFG};
        end else begin
            shd_q <= shd_d;
        end
    end

    assign active = shd_q.act;
endmodule

// File: rtl/ncp_gates.sv
module ncp_gates
    import ncp_pkg::*;
(
    input  cnt_t  count,
    input  cfg_t  cfg,
    output gate_t gates
);
    localparam int unsigned W = CW + 2;
    typedef logic [W-1:0] wide_t;
    localparam wide_t ONE = wide_t'(1);

    wide_t lvl, per, duty, deff, lo_start, lo_w, inset, minon;

    always_comb begin
        lvl      = wide_t'(count);
        per      = wide_t'(cfg.period);
        duty     = wide_t'(cfg.duty);
        inset    = wide_t'(cfg.inset);
        minon    = wide_t'(cfg.minon);
        deff     = (duty > per) ? per : duty;
        lo_start = deff + wide_t'(cfg.dead);
        lo_w     = ((per + ONE) > lo_start) ? (per + ONE - lo_start) : '0;

        gates.hi_fast = (lvl < deff);
        gates.hi_slow = (deff >= minon) && ((lvl + inset) < deff);
        gates.lo_fast = (lvl >= lo_start);
        gates.lo_slow = (lo_w >= minon) && (lo_w != '0) && (lvl >= (lo_start + inset));
    end
endmodule

// File: rtl/ncp_top.sv
module ncp_top
    import ncp_pkg::*;
#(
    parameter int unsigned RST_PERIOD = 16,
    parameter int unsigned RST_DUTY   = 0,
    parameter int unsigned RST_DEAD   = 1,
    parameter int unsigned RST_INSET  = 1,
    parameter int unsigned RST_MINON  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     reload_both,
    input  logic                     wr_en,
    input  logic [ncp_pkg::CW-1:0]   wr_period,
    input  logic [ncp_pkg::CW-1:0]   wr_duty,
    input  logic [ncp_pkg::CW-1:0]   wr_dead,
    input  logic [ncp_pkg::CW-1:0]   wr_inset,
    input  logic [ncp_pkg::CW-1:0]   wr_minon,
    output logic                     hi_fast,
    output logic                     hi_slow,
    output logic                     lo_fast,
    output logic                     lo_slow,
    output logic                     adc_trig,
    output logic                     reload_pulse
);
    localparam cfg_t RST_CFG = '{
        period: cnt_t'(RST_PERIOD),
        duty:   cnt_t'(RST_DUTY),
        dead:   cnt_t'(RST_DEAD),
        inset:  cnt_t'(RST_INSET),
        minon:  cnt_t'(RST_MINON)
    };

    typedef struct packed {
        gate_t g;
        logic  run;
        logic  trig;
        logic  rld;
    } out_t;

    out_t  st_d, st_q;
    cfg_t  act_cfg;
    cfg_t  wr_cfg;
    cnt_t  count;
    logic  at_top, at_bot, load;
    gate_t raw;

    assign wr_cfg = '{period: wr_period, duty: wr_duty, dead: wr_dead,
                      inset: wr_inset, minon: wr_minon};
    assign load   = at_top || (reload_both && at_bot);

    ncp_carrier u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (act_cfg.period),
        .count  (count),
        .at_top (at_top),
        .at_bot (at_bot)
    );

    ncp_shadow #(.RST_CFG(RST_CFG)) u_shd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_cfg (wr_cfg),
        .load   (load),
        .active (act_cfg)
    );

    ncp_gates u_gts (
        .count (count),
        .cfg   (act_cfg),
        .gates (raw)
    );

    always_comb begin
        st_d      = st_q;
        st_d.run  = en && (st_q.run || at_bot);
        st_d.g    = (en && st_q.run) ? raw : '0;
        st_d.trig = at_top;
        st_d.rld  = load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_fast      = st_q.g.hi_fast;
    assign hi_slow      = st_q.g.hi_slow;
    assign lo_fast      = st_q.g.lo_fast;
    assign lo_slow      = st_q.g.lo_slow;
    assign adc_trig     = st_q.trig;
    assign reload_pulse = st_q.rld;
endmodule

// File: rtl/ncp_checker.sv
module ncp_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic hi_fast,
    input logic hi_slow,
    input logic lo_fast,
    input logic lo_slow,
    input logic adc_trig
);
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !((hi_fast || hi_slow) && (lo_fast || lo_slow)));

    p_hi_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_slow |-> hi_fast);

    p_lo_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_slow |-> lo_fast);

    p_disable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(hi_fast || hi_slow || lo_fast || lo_slow));

    p_trig_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);
endmodule

bind ncp_top ncp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .hi_fast  (hi_fast),
    .hi_slow  (hi_slow),
    .lo_fast  (lo_fast),
    .lo_slow  (lo_slow),
    .adc_trig (adc_trig)
);

// File: tb/tb_ncp_top.sv
module tb_ncp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        reload_both = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_period = '0, wr_duty = '0, wr_dead = '0, wr_inset = '0, wr_minon = '0;
    logic        hi_fast, hi_slow, lo_fast, lo_slow, adc_trig, reload_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ncp_top dut (
        .clk(clk), .rst_n(rst_n), .en(en), .reload_both(reload_both),
        .wr_en(wr_en), .wr_period(wr_period), .wr_duty(wr_duty), .wr_dead(wr_dead),
        .wr_inset(wr_inset), .wr_minon(wr_minon),
        .hi_fast(hi_fast), .hi_slow(hi_slow), .lo_fast(lo_fast), .lo_slow(lo_slow),
        .adc_trig(adc_trig), .reload_pulse(reload_pulse)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_trig();
        tick();
        for (int g = 0; g < 1000 && !adc_trig; g++) tick();
    endtask

    function automatic int gates_on();
        return int'(hi_fast) + int'(hi_slow) + int'(lo_fast) + int'(lo_slow);
    endfunction

    task automatic set_wr(input int p, input int d, input int t, input int s, input int m);
        wr_period = 16'(p); wr_duty = 16'(d); wr_dead = 16'(t);
        wr_inset = 16'(s); wr_minon = 16'(m);
    endtask

    task automatic apply_cfg(input int p, input int d, input int t, input int s, input int m);
        set_wr(p, d, t, s, m);
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        wait_trig();
        wait_trig();
    endtask

    // One peak-to-peak window; sreq tags the slow-gate counts.
    task automatic measure(input int p, input int efh, input int esh, input int efl,
                           input int esl, input string sreq);
        int fh = 0, sh = 0, fl = 0, sl = 0, ovl = 0, nest = 0, extra = 0, peak_sl;
        wait_trig();
        peak_sl = int'(lo_slow);
        for (int i = 0; i < 2 * p; i++) begin
            if (i > 0) tick();
            fh += int'(hi_fast); sh += int'(hi_slow);
            fl += int'(lo_fast); sl += int'(lo_slow);
            if ((hi_fast || hi_slow) && (lo_fast || lo_slow)) ovl++;
            if ((hi_slow && !hi_fast) || (lo_slow && !lo_fast)) nest++;
            if (i > 0 && adc_trig) extra++;
        end
        tick();
        chk("R1", "trigger after 2P clocks", int'(adc_trig), 1);
        chk("R1", "extra triggers in window", extra, 0);
        chk("R1", "slow low gate at peak", peak_sl, (esl > 0) ? 1 : 0);
        chk("R2", "hi_fast on-clocks", fh, efh);
        chk(sreq, "hi_slow on-clocks", sh, esh);
        chk("R3", "lo_fast on-clocks", fl, efl);
        chk(sreq, "lo_slow on-clocks", sl, esl);
        chk("R3", "overlap clocks", ovl, 0);
        chk("R4", "nesting violations", nest, 0);
    endtask

    task automatic t_reset();
        int first = 0;
        rst_n = 1'b0;
        repeat (5) tick();
        chk("R6", "gates in reset", gates_on(), 0);
        chk("R6", "trig/reload in reset", int'(adc_trig) + int'(reload_pulse), 0);
        rst_n = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            tick();
            if (k == 1) chk("R6", "gates at level 0 after reset", gates_on(), 0);
            if (adc_trig && first == 0) first = k;
        end
        chk("R9", "first trigger clock after reset", first, 17);
    endtask

    task automatic t_basic();
        apply_cfg(20, 8, 2, 2, 3);
        measure(20, 15, 11, 21, 17, "R4");
    endtask

    task automatic t_short_period();
        apply_cfg(12, 5, 1, 1, 2);
        measure(12, 9, 7, 13, 11, "R4");
    endtask

    task automatic t_duty_zero();
        apply_cfg(20, 0, 2, 2, 3);
        measure(20, 0, 0, 37, 33, "R2");
    endtask

    task automatic t_duty_clamp();
        apply_cfg(20, 30, 2, 2, 3);
        measure(20, 39, 35, 0, 0, "R2");
    endtask

    task automatic t_minon_high();
        apply_cfg(20, 4, 2, 2, 5);
        measure(20, 7, 0, 29, 25, "R5");
    endtask

    task automatic t_minon_low();
        apply_cfg(20, 15, 2, 1, 5);
        measure(20, 29, 27, 7, 0, "R5");
    endtask

    task automatic t_shadow();
        int fh, rl, rl_bot;
        apply_cfg(20, 12, 2, 2, 3);
        wait_trig();
        set_wr(20, 6, 2, 2, 3);
        wr_en = 1'b1;
        fh = int'(hi_fast); rl = int'(reload_pulse);
        for (int i = 1; i < 40; i++) begin
            tick();
            if (i == 1) wr_en = 1'b0;
            fh += int'(hi_fast); rl += int'(reload_pulse);
        end
        chk("R8", "peak-only: current pulse keeps old duty", fh, 23);
        chk("R8", "peak-only: reload strobes per period", rl, 1);
        measure(20, 11, 7, 25, 21, "R8");
        // measure leaves us on a peak clock
        reload_both = 1'b1;
        set_wr(20, 12, 2, 2, 3);
        wr_en = 1'b1;
        fh = int'(hi_fast); rl = int'(reload_pulse); rl_bot = 0;
        for (int i = 1; i < 40; i++) begin
            tick();
            if (i == 1) wr_en = 1'b0;
            fh += int'(hi_fast); rl += int'(reload_pulse);
            if (i == 20) rl_bot = int'(reload_pulse);
        end
        chk("R8", "dual: new duty from bottom on", fh, 17);
        chk("R8", "dual: reload strobes per period", rl, 2);
        chk("R8", "dual: strobe at bottom", rl_bot, 1);
        reload_both = 1'b0;
    endtask

    task automatic t_enable();
        int z = 0, fh = 0;
        apply_cfg(20, 8, 2, 2, 3);
        en = 1'b0;
        tick();
        for (int i = 0; i < 40; i++) begin
            tick();
            z += gates_on();
        end
        chk("R7", "gates while disabled", z, 0);
        wait_trig();
        en = 1'b1;
        z = 0;
        for (int i = 1; i < 40; i++) begin
            tick();
            if (i <= 20) z += gates_on();
            else fh += int'(hi_fast);
        end
        chk("R7", "gates before bottom after re-enable", z, 0);
        chk("R7", "hi_fast clocks after bottom", fh, 7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_short_period();
        t_duty_zero();
        t_duty_clamp();
        t_minon_high();
        t_minon_low();
        t_shadow();
        t_enable();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule